// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This block sequences a multiplexed analog-to-digital converter inside a codec-style peripheral. The host writes a control word carrying four things: a power enable, a channel number for the input multiplexer, a flag that makes the conversion wait for an external sync signal, and a start flag. Every phase of a conversion is timed in ticks of the serial bus clock, which reaches the block as a one-cycle enable, `bus_tick`. There are three timed phases. The reference settles after power-up. The selected input settles after a channel change. The conversion then runs. The analog converter is outside the block. Its result arrives on `conv_result` and is captured when the conversion phase ends.

The host works in a fixed order. It first writes the channel, and then writes the same word again with the start flag set. It then polls `data_valid` until a result is present. A one-cycle `done_irq` pulse also marks every completion and feeds the peripheral's interrupt logic. Clearing the enable aborts the sequence at once. The defaults follow a serial clock of about 12 MHz: 60 ticks of reference settling (about 5 µs), 51 ticks of input settling, and 102 ticks of conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `data_valid`, `done_irq`, `data_value` and `mux_chan` are all zero.
- R2: A write that sets the enable while the block is disabled restarts the reference settling. No conversion begins until REF_TICKS bus ticks have passed since that write.
- R3: Every write updates `mux_chan` on the next cycle. The input settling restarts, needing SEL_TICKS bus ticks, in two cases: the written channel differs from the current one, or the block was disabled. A pending start does not enter conversion before both settling phases are complete.
- R4: Once armed and settled, the block enters conversion on the following cycle. The result is then due on the CONV_TICKS-th bus tick after entry. A start written to a settled block with an unchanged channel therefore completes 1+CONV_TICKS cycles after its write edge when `bus_tick` is high every cycle.
- R5: A start write clears `data_valid` on the cycle after its edge. On completion, `data_value` holds the `conv_result` value sampled at the completing edge.
- R6: `done_irq` is high for exactly one cycle, on the same cycle `data_valid` rises.
- R7: When the start write has the sync flag set, conversion waits for a rising edge on `sync_pin` seen while armed. The pin passes through a two-flop synchronizer, so conversion begins on the third clock edge after the pin is first sampled high. A pin that was already high before the start does not trigger the conversion.
- R8: A write with the enable clear drops `data_valid` on the next cycle. It also abandons any armed or running conversion, and no completion or interrupt follows.
- R9: The settling and conversion counters advance only on cycles where `bus_tick` is high. With `bus_tick` held low, a running conversion never completes.
- R10: A start write during a running conversion abandons it and re-arms. The completion is then timed from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One-cycle enable, one per serial bus clock period |
| wr_en | input | 1 | Control word write strobe |
| wr_enable | input | 1 | Written power enable for converter and reference |
| wr_sync_en | input | 1 | Written flag: wait for the sync pin before converting |
| wr_start | input | 1 | Written start flag |
| wr_chan | input | CH_W | Written input channel number |
| sync_pin | input | 1 | External asynchronous sync signal |
| conv_result | input | RES_W | Result from the analog converter model |
| mux_chan | output | CH_W | Channel driven to the input multiplexer |
| data_valid | output | 1 | Result present flag, polled by the host |
| data_value | output | RES_W | Captured conversion result |
| done_irq | output | 1 | One-cycle completion interrupt source |

## Verification
Each completion is due on a cycle the bench predicts from the requirements. That cycle is 1+CONV_TICKS edges after a settled start. When settling must finish first, the larger settling count is added. For a synced start, the count is CONV_TICKS+3 edges from the sync rise. After a tick freeze it is CONV_TICKS tick edges. A helper checks that neither `data_valid` nor `done_irq` appears on any earlier edge, checks both together with the captured value on the due edge, and checks that the interrupt has dropped one edge later. Abort, tick-freeze and early-sync cases instead watch the outputs over a long quiet window. All outputs are sampled 1 ns after the rising edge, and inputs change on falling edges.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_settle_timer.sv
`timescale 1ns/1ps
// Saturating tick counter: done once LIMIT ticks have elapsed since clr.
module adc_settle_timer #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == CW'(LIMIT));
  assign cnt_en = clr || (tick && !done);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3/R2: a clear always withdraws the settled indication on the next cycle
  p_clear_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);

  // R9: without a tick the settled indication cannot appear
  p_no_tick_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !done) |=> !done);
endmodule

// File: rtl/adc_sync_edge.sv
`timescale 1ns/1ps
// Synchronizer chain followed by a rising-edge detector.
module adc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_d;

  assign sh_d = {sh_q[STAGES-1:0], pin};
  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R7: one pin edge gives exactly one rise pulse
  p_single_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/adc_conv_core.sv
`timescale 1ns/1ps
// Arm / convert sequencer with result capture and completion pulse.
module adc_conv_core
  import adc_seq_pkg::*;
#(
  parameter int CONV_TICKS = 102,
  parameter int RES_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_req,
  input  logic             abort,
  input  logic             sync_mode,
  input  logic             ref_ok,
  input  logic             sel_ok,
  input  logic             sync_rise,
  input  logic [RES_W-1:0] result_in,
  output logic             valid,
  output logic [RES_W-1:0] data,
  output logic             irq
);
  localparam int CNT_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_TICKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_d;
  logic             valid_q, valid_d;
  logic             irq_q, irq_d;
  logic             cap_en;
  logic [RES_W-1:0] data_q;
  logic             go;

  assign go = ref_ok && sel_ok && (!sync_q || sync_rise);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sync_d  = sync_q;
    valid_d = valid_q;
    irq_d   = 1'b0;
    cap_en  = 1'b0;
    if (abort) begin
      state_d = SEQ_IDLE;
      valid_d = 1'b0;
    end else if (start_req) begin
      state_d = SEQ_ARMED;
      valid_d = 1'b0;
      sync_d  = sync_mode;
    end else begin
      case (state_q)
        SEQ_ARMED: if (go) begin
          state_d = SEQ_CONV;
          cnt_d   = '0;
        end
        SEQ_CONV: if (tick) begin
          if (cnt_q == LAST) begin
            state_d = SEQ_IDLE;
            valid_d = 1'b1;
            irq_d   = 1'b1;
            cap_en  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sync_q  <= sync_d;
      valid_q <= valid_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= result_in;
  end

  assign valid = valid_q;
  assign irq   = irq_q;
  assign data  = data_q;

  // R2/R3: an unsettled armed sequencer never enters conversion
  p_no_unsettled_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARMED && !(ref_ok && sel_ok)) |=> state_q != SEQ_CONV);
  // R4: a result only appears at the end of the conversion phase
  p_valid_from_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(state_q) == SEQ_CONV);
  // R5: a start always withdraws the previous result
  p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !valid);
  // R6: interrupt is a single cycle and coincides with a present result
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);
  // R8: an abort drops the result and leaves nothing running
  p_abort_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!valid && state_q == SEQ_IDLE));
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Top: control word decode, settling timers, sync gate and sequencer.
module adc_seq_ctrl #(
  parameter int CH_W       = 3,
  parameter int RES_W      = 10,
  parameter int REF_TICKS  = 60,
  parameter int SEL_TICKS  = 51,
  parameter int CONV_TICKS = 102,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_tick,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic             wr_sync_en,
  input  logic             wr_start,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             sync_pin,
  input  logic [RES_W-1:0] conv_result,
  output logic [CH_W-1:0]  mux_chan,
  output logic             data_valid,
  output logic [RES_W-1:0] data_value,
  output logic             done_irq
);
  logic            rst_meta, rst_q;
  logic            en_q;
  logic [CH_W-1:0] chan_q;
  logic            ref_clr, sel_clr, start_req, abort;
  logic            ref_ok, sel_ok, sync_rise;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q   <= 1'b0;
      chan_q <= '0;
    end else if (wr_en) begin
      en_q   <= wr_enable;
      chan_q <= wr_chan;
    end
  end

  assign start_req = wr_en && wr_enable && wr_start;
  assign abort     = wr_en && !wr_enable;
  assign ref_clr   = !en_q || abort;
  assign sel_clr   = !en_q || abort || (wr_en && (wr_chan != chan_q));
  assign mux_chan  = chan_q;

  adc_settle_timer #(.LIMIT(REF_TICKS)) u_ref_timer (
    .clk(clk), .rst_n(rst_q), .tick(bus_tick), .clr(ref_clr), .done(ref_ok)
  );

  adc_settle_timer #(.LIMIT(SEL_TICKS)) u_sel_timer (
    .clk(clk), .rst_n(rst_q), .tick(bus_tick), .clr(sel_clr), .done(sel_ok)
  );

  adc_sync_edge #(.STAGES(SYNC_STG)) u_sync_edge (
    .clk(clk), .rst_n(rst_q), .pin(sync_pin), .rise(sync_rise)
  );

  adc_conv_core #(.CONV_TICKS(CONV_TICKS), .RES_W(RES_W)) u_core (
    .clk(clk), .rst_n(rst_q), .tick(bus_tick),
    .start_req(start_req), .abort(abort), .sync_mode(wr_sync_en),
    .ref_ok(ref_ok), .sel_ok(sel_ok), .sync_rise(sync_rise),
    .result_in(conv_result),
    .valid(data_valid), .data(data_value), .irq(done_irq)
  );

  // R3: the multiplexer follows every control write
  p_mux_follows_r3: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en |=> mux_chan == $past(wr_chan));
  // R8: a disabled block raises no completion
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!en_q && !wr_en) |=> !done_irq);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  localparam int CH_W = 3;
  localparam int RES_W = 10;
  localparam int REF = 60;
  localparam int SEL = 51;
  localparam int CT = 102;

  logic             clk;
  logic             rst_n;
  logic             bus_tick;
  logic             wr_en, wr_enable, wr_sync_en, wr_start;
  logic [CH_W-1:0]  wr_chan;
  logic             sync_pin;
  logic [RES_W-1:0] conv_result;
  logic [CH_W-1:0]  mux_chan;
  logic             data_valid;
  logic [RES_W-1:0] data_value;
  logic             done_irq;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;
  logic [CH_W-1:0] cur_ch;

  adc_seq_ctrl #(
    .CH_W(CH_W), .RES_W(RES_W), .REF_TICKS(REF), .SEL_TICKS(SEL), .CONV_TICKS(CT)
  ) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick),
    .wr_en(wr_en), .wr_enable(wr_enable), .wr_sync_en(wr_sync_en),
    .wr_start(wr_start), .wr_chan(wr_chan), .sync_pin(sync_pin),
    .conv_result(conv_result), .mux_chan(mux_chan),
    .data_valid(data_valid), .data_value(data_value), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int due(bit cold, bit newch);
    int settle = 0;
    if (cold) settle = REF;
    if (newch && SEL > settle) settle = SEL;
    return settle + 1 + CT;
  endfunction

  task automatic write_ctl(bit en, bit sy, bit st, logic [CH_W-1:0] ch);
    @(negedge clk);
    wr_en = 1'b1; wr_enable = en; wr_sync_en = sy; wr_start = st; wr_chan = ch;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_start = 1'b0;
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (data_valid || done_irq) seen++;
    end
    chk(req, "unexpected completion cycles", seen, 0);
  endtask

  // k counts rising edges from the next one; the result is due on edge k
  task automatic expect_done(int k, string req, logic [RES_W-1:0] val);
    int early = 0;
    for (int i = 1; i < k; i++) begin
      @(posedge clk); #1;
      if (data_valid || done_irq) early++;
    end
    chk(req, "completion before due cycle", early, 0);
    @(posedge clk); #1;
    chk(req, "data_valid on due cycle", data_valid, 1);
    chk("R6", "done_irq with valid", done_irq, 1);
    chk("R5", "captured result", data_value, val);
    @(posedge clk); #1;
    chk("R6", "done_irq single cycle", done_irq, 0);
    chk("R5", "valid held after completion", data_valid, 1);
  endtask

  initial begin
    int seed;
    int gap;
    bit newch;
    logic [CH_W-1:0] nch;
    seed = $urandom(32'h5EED_0A1C);
    rst_n = 1'b0; bus_tick = 1'b1; wr_en = 1'b0; wr_enable = 1'b0;
    wr_sync_en = 1'b0; wr_start = 1'b0; wr_chan = '0; sync_pin = 1'b0;
    conv_result = '0;
    repeat (5) @(posedge clk);
    #1;
    chk("R1", "reset data_valid", data_valid, 0);
    chk("R1", "reset done_irq", done_irq, 0);
    chk("R1", "reset data_value", data_value, 0);
    chk("R1", "reset mux_chan", mux_chan, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R2: enable and start in one write from cold
    cur_ch = 3'd5; conv_result = 10'h2A5;
    write_ctl(1, 0, 1, cur_ch);
    chk("R3", "mux_chan after write", mux_chan, 5);
    expect_done(due(1, 1), "R2", 10'h2A5);

    // R5/R4: restart on settled block, valid cleared by start
    conv_result = 10'h13C;
    write_ctl(1, 0, 1, cur_ch);
    chk("R5", "valid cleared by start", data_valid, 0);
    expect_done(due(0, 0), "R4", 10'h13C);

    // R3: start with a new channel waits for input settling
    cur_ch = 3'd2; conv_result = 10'h0F1;
    write_ctl(1, 0, 1, cur_ch);
    expect_done(due(0, 1), "R3", 10'h0F1);

    // R3: select, gap of 10 cycles, then start
    cur_ch = 3'd6; conv_result = 10'h3FF;
    write_ctl(1, 0, 0, cur_ch);
    repeat (10) @(posedge clk);
    #1;
    write_ctl(1, 0, 1, cur_ch);
    expect_done(SEL - 10 + CT, "R3", 10'h3FF);

    // R10: second start during conversion restarts the timing
    conv_result = 10'h055;
    write_ctl(1, 0, 1, cur_ch);
    quiet(40, "R10");
    conv_result = 10'h2AA;
    write_ctl(1, 0, 1, cur_ch);
    chk("R10", "valid low after restart", data_valid, 0);
    expect_done(1 + CT, "R10", 10'h2AA);

    // R7: sync-gated start waits for a pin edge
    conv_result = 10'h111;
    write_ctl(1, 1, 1, cur_ch);
    quiet(30, "R7");
    @(negedge clk); sync_pin = 1'b1;
    expect_done(CT + 3, "R7", 10'h111);
    @(negedge clk); sync_pin = 1'b0;
    repeat (5) @(posedge clk);
    #1;

    // R7: pin already high before the start is not an edge
    @(negedge clk); sync_pin = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    conv_result = 10'h222;
    write_ctl(1, 1, 1, cur_ch);
    quiet(250, "R7");
    @(negedge clk); sync_pin = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); sync_pin = 1'b1;
    expect_done(CT + 3, "R7", 10'h222);
    @(negedge clk); sync_pin = 1'b0;

    // R9: no bus ticks, no progress
    @(negedge clk); bus_tick = 1'b0;
    conv_result = 10'h333;
    write_ctl(1, 0, 1, cur_ch);
    quiet(200, "R9");
    @(negedge clk); bus_tick = 1'b1;
    expect_done(CT, "R9", 10'h333);

    // R8: disable aborts a running conversion
    conv_result = 10'h044;
    write_ctl(1, 0, 1, cur_ch);
    repeat (40) @(posedge clk);
    #1;
    write_ctl(0, 0, 0, cur_ch);
    chk("R8", "valid after disable", data_valid, 0);
    quiet(300, "R8");
    conv_result = 10'h099;
    write_ctl(1, 0, 1, cur_ch);
    expect_done(due(1, 1), "R2", 10'h099);
    write_ctl(0, 0, 0, cur_ch);
    chk("R8", "completed result dropped by disable", data_valid, 0);
    cur_ch = 3'd1; conv_result = 10'h1E0;
    write_ctl(1, 0, 1, cur_ch);
    expect_done(due(1, 1), "R2", 10'h1E0);

    // random channel mix with random idle gaps
    for (int it = 0; it < 12; it++) begin
      newch = 1'($urandom_range(0, 1));
      nch = newch ? cur_ch + CH_W'($urandom_range(1, (1 << CH_W) - 1)) : cur_ch;
      gap = $urandom_range(0, 20);
      repeat (gap) @(posedge clk);
      #1;
      cur_ch = nch;
      conv_result = RES_W'($urandom);
      write_ctl(1, 0, 1, cur_ch);
      chk("R3", "mux_chan random", mux_chan, cur_ch);
      expect_done(due(0, newch), "R4", conv_result);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule